// File: doc/BRIEF.md
# GPIO Interrupt Channel Multiplexer

This block takes a wide bank of GPIO pad inputs and routes a handful of them onto a small set of interrupt outputs. Each output channel has an 8-bit selector that picks one pad. The chosen pad is synchronised and optionally debounced. It can then be inverted, and is finally presented either as a level or as a one-clock pulse.

Inversion lets a channel report a low level or a falling edge while its output stays active-high, or rising in edge mode. The parent interrupt controller therefore only ever needs to handle high levels and rising edges. A channel watches exactly one edge direction, never both.

Software programs the block through a small register bank on a synchronous bus with no wait states. The bus has a byte address, a write strobe, 32-bit write data and registered read data. Each channel's fields sit in shared 32-bit words. Software edits them with read-modify-write, and a write touches only the word it addresses.

Top module: `gpio_irq_chmux`

## Requirements
- R1: After reset every register reads zero, every irq output is 0, and every channel is in level mode, active-high, selecting pad 0.
- R2: The word at byte offset 0x00 holds the channel modes: bit n set gives channel n edge mode, and bit 16+n set gives channel n inverted polarity (low level or falling edge). Bits 8..15 and 24..31 read as zero.
- R3: The word at 0x04 holds the pad selectors of channels 0..3, and the word at 0x08 those of channels 4..7. Each selector is 8 bits wide at bit (n mod 4)*8, and channel n follows pad_i[selector n].
- R4: The word at 0x0c holds a 4-bit debounce value for channel n at bit n*4, and it reads back as written.
- R5: A write changes only the addressed word. Reads and writes at any other offset (0x10..0x3c) have no effect and read as zero. Read data appears on the clock edge after the address is presented.
- R6: In level mode, active-high, with debounce 0, a pad change reaches irq_o on the fourth rising clock edge after it is applied.
- R7: In level mode with inverted polarity, irq_o is the complement of the selected pad.
- R8: In edge mode, active-high, a rising pad edge gives exactly one single-cycle irq pulse, and a falling edge gives none.
- R9: In edge mode with inverted polarity, a falling pad edge gives exactly one single-cycle pulse, and a rising edge gives none.
- R10: With debounce value N nonzero, a pad level held for fewer than N*8 clock cycles is ignored, and one held for N*8 cycles or more is accepted.
- R11: Channels act independently: each output depends only on its own selector, mode and debounce value, whatever the other channels are set to.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_i | input | NUM_PADS | Asynchronous GPIO pad levels |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NUM_CH | Active-high interrupt per channel (level or pulse) |

## Verification
The hardest behaviour to reach is the debounce boundary, where a pulse of N*8-1 cycles must be dropped and one of N*8 cycles kept, separately for every nonzero N. The stimulus gives each channel a different debounce value and its own pad. It then applies pulses whose lengths step across every channel's boundary, so a single pulse length probes all eight thresholds at once. A second sweep gives each channel a different mode in rotation, which shows that polarity and edge settings stay separate between channels that share one control word.

// File: rtl/gim_pkg.sv
package gim_pkg;
  localparam int REG_W = 32;

  typedef struct packed {
    logic edge_mode;  // 1: pulse on transition, 0: follow level
    logic act_low;    // 1: invert pad before detection
  } ch_mode_t;
endpackage

// File: rtl/gim_regs.sv
module gim_regs #(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = 8,
  parameter int FILT_W = 4,
  parameter int ADDR_W = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              wr_en,
  input  logic [gim_pkg::REG_W-1:0]         wr_data,
  output logic [gim_pkg::REG_W-1:0]         rd_data,
  output gim_pkg::ch_mode_t [NUM_CH-1:0]    mode_o,
  output logic [NUM_CH-1:0][SEL_W-1:0]      sel_o,
  output logic [NUM_CH-1:0][FILT_W-1:0]     filt_o
);
  import gim_pkg::*;

  localparam int IDX_W     = ADDR_W - 2;
  localparam int SPW       = REG_W / SEL_W;
  localparam int SEL_WORDS = (NUM_CH + SPW - 1) / SPW;
  localparam int POL_LSB   = REG_W / 2;
  localparam logic [IDX_W-1:0] MODE_IDX = '0;
  localparam int SEL_BASE  = 1;
  localparam logic [IDX_W-1:0] FILT_IDX = IDX_W'(SEL_BASE + SEL_WORDS);

  logic [IDX_W-1:0]  widx;
  logic [REG_W-1:0]  rd_next;

  assign widx = addr[ADDR_W-1:2];

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
    localparam logic [IDX_W-1:0] MY_SEL_IDX = IDX_W'(SEL_BASE + gc / SPW);
    localparam int SEL_LSB = (gc % SPW) * SEL_W;

    ch_mode_t          m_q;
    logic [SEL_W-1:0]  s_q;
    logic [FILT_W-1:0] f_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        m_q <= '0;
        s_q <= '0;
        f_q <= '0;
      end else if (wr_en) begin
        if (widx == MODE_IDX) begin
          m_q.edge_mode <= wr_data[gc];
          m_q.act_low   <= wr_data[POL_LSB + gc];
        end
        if (widx == MY_SEL_IDX) s_q <= wr_data[SEL_LSB +: SEL_W];
        if (widx == FILT_IDX)   f_q <= wr_data[gc*FILT_W +: FILT_W];
      end
    end

    assign mode_o[gc] = m_q;
    assign sel_o[gc]  = s_q;
    assign filt_o[gc] = f_q;
  end

  always_comb begin
    rd_next = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (widx == MODE_IDX) begin
        rd_next[c]           = mode_o[c].edge_mode;
        rd_next[POL_LSB + c] = mode_o[c].act_low;
      end
      if (widx == IDX_W'(SEL_BASE + c / SPW))
        rd_next[(c % SPW)*SEL_W +: SEL_W] = sel_o[c];
      if (widx == FILT_IDX)
        rd_next[c*FILT_W +: FILT_W] = filt_o[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R5: a write aimed at another word leaves the mode word untouched
  a_r5_mode_isolated: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && ($past(widx) != MODE_IDX)) |-> $stable(mode_o));

  // R5: offsets past the last defined word read as zero
  a_r5_unused_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(widx) > FILT_IDX) |-> (rd_data == '0));
endmodule

// File: rtl/gim_channel.sv
module gim_channel #(
  parameter int FILT_W    = 4,
  parameter int FILT_UNIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pad_i,
  input  gim_pkg::ch_mode_t mode_i,
  input  logic [FILT_W-1:0] filt_i,
  output logic              irq_o
);
  localparam int CNT_W = FILT_W + $clog2(FILT_UNIT) + 1;

  logic             s1_q, s2_q;
  logic             flt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             bypass;
  logic             lvl, lvl_prev_q;
  logic             irq_q;

  assign bypass = (filt_i == '0);
  assign lim    = CNT_W'(filt_i) * CNT_W'(FILT_UNIT) - CNT_W'(1);

  // two-stage synchroniser for the asynchronous pad
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pad_i;
      s2_q <= s1_q;
    end
  end

  // debounce: a new value must persist for lim+1 cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      flt_q <= 1'b0;
      cnt_q <= '0;
    end else if (bypass) begin
      flt_q <= s2_q;
      cnt_q <= '0;
    end else if (s2_q == flt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == lim) begin
      flt_q <= s2_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign lvl = flt_q ^ mode_i.act_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_prev_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      lvl_prev_q <= lvl;
      irq_q      <= mode_i.edge_mode ? (lvl & ~lvl_prev_q) : lvl;
    end
  end

  assign irq_o = irq_q;

  // R8: an edge-mode pulse never lasts longer than one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (irq_q && mode_i.edge_mode) |=> !irq_q);

  // R10: the debounced level only ever takes a value the synchroniser held
  a_r10_accept_sampled: assert property (@(posedge clk) disable iff (rst)
    $changed(flt_q) |-> (flt_q == $past(s2_q)));
endmodule

// File: rtl/gpio_irq_chmux.sv
module gpio_irq_chmux #(
  parameter int NUM_CH    = 8,
  parameter int NUM_PADS  = 256,
  parameter int FILT_W    = 4,
  parameter int FILT_UNIT = 8,
  parameter int ADDR_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] pad_i,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_CH-1:0]   irq_o
);
  localparam int SEL_W = $clog2(NUM_PADS);

  gim_pkg::ch_mode_t [NUM_CH-1:0] mode;
  logic [NUM_CH-1:0][SEL_W-1:0]   sel;
  logic [NUM_CH-1:0][FILT_W-1:0]  filt;

  gim_regs #(
    .NUM_CH (NUM_CH),
    .SEL_W  (SEL_W),
    .FILT_W (FILT_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .wr_en   (bus_wr),
    .wr_data (bus_wdata),
    .rd_data (bus_rdata),
    .mode_o  (mode),
    .sel_o   (sel),
    .filt_o  (filt)
  );

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chan
    logic picked;
    assign picked = pad_i[sel[gc]];

    gim_channel #(
      .FILT_W    (FILT_W),
      .FILT_UNIT (FILT_UNIT)
    ) u_chan (
      .clk    (clk),
      .rst    (rst),
      .pad_i  (picked),
      .mode_i (mode[gc]),
      .filt_i (filt[gc]),
      .irq_o  (irq_o[gc])
    );
  end
endmodule

// File: tb/gpio_irq_chmux_bench.sv
module gpio_irq_chmux_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [255:0] pads = '0;
  logic [5:0]   addr = '0;
  logic         wr = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [7:0]   irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int hi_cnt[8];

  always #4 clk = ~clk;

  gpio_irq_chmux u_gpio_irq_chmux (
    .clk(clk), .rst(rst), .pad_i(pads), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic window(input int n);
    for (int c = 0; c < 8; c++) hi_cnt[c] = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int c = 0; c < 8; c++) if (irq[c]) hi_cnt[c]++;
    end
  endtask

  task automatic set_sel_all(input logic [7:0] s0, input logic [7:0] step);
    logic [7:0] s[8];
    for (int c = 0; c < 8; c++) s[c] = s0 + 8'(c) * step;
    wr_reg(6'h04, {s[3], s[2], s[1], s[0]});
    wr_reg(6'h08, {s[7], s[6], s[5], s[4]});
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(irq == 8'h00, "R1 irq after reset", {24'h0, irq}, 32'h0);
    rd_reg(6'h00, d); check(d == 0, "R1 mode word", d, 0);
    rd_reg(6'h04, d); check(d == 0, "R1 sel word 0", d, 0);
    rd_reg(6'h08, d); check(d == 0, "R1 sel word 1", d, 0);
    rd_reg(6'h0c, d); check(d == 0, "R1 filter word", d, 0);

    // R1 + R6: defaults route pad 0 active-high, 4-edge latency
    @(negedge clk); pads[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); check(irq == 8'h00, "R6 before 4th edge", {24'h0, irq}, 0);
    @(posedge clk);
    @(negedge clk); check(irq == 8'hFF, "R6 R1 at 4th edge", {24'h0, irq}, 32'hFF);
    @(negedge clk); pads[0] = 1'b0;
    repeat (6) @(negedge clk);
    check(irq == 8'h00, "R6 follows fall", {24'h0, irq}, 0);

    // R2 R3 R4 R5: register layout and isolation
    wr_reg(6'h00, 32'hFFFF_FFFF);
    rd_reg(6'h00, d); check(d == 32'h00FF_00FF, "R2 mode reserved bits", d, 32'h00FF00FF);
    wr_reg(6'h00, 32'h0000_0000);
    wr_reg(6'h04, 32'h3322_1100);
    wr_reg(6'h08, 32'h7766_5544);
    wr_reg(6'h0c, 32'h89AB_CDEF);
    rd_reg(6'h04, d); check(d == 32'h3322_1100, "R3 sel word 0", d, 32'h33221100);
    rd_reg(6'h08, d); check(d == 32'h7766_5544, "R3 sel word 1", d, 32'h77665544);
    rd_reg(6'h0c, d); check(d == 32'h89AB_CDEF, "R4 filter word", d, 32'h89ABCDEF);
    wr_reg(6'h04, 32'hA5A5_A5A5);
    rd_reg(6'h08, d); check(d == 32'h7766_5544, "R5 sel1 kept", d, 32'h77665544);
    rd_reg(6'h0c, d); check(d == 32'h89AB_CDEF, "R5 filter kept", d, 32'h89ABCDEF);
    for (int a = 16; a < 64; a += 4) begin
      wr_reg(6'(a), 32'hFFFF_FFFF);
      rd_reg(6'(a), d); check(d == 0, "R5 unused offset reads zero", d, 0);
    end
    rd_reg(6'h00, d); check(d == 0, "R5 mode kept", d, 0);
    rd_reg(6'h04, d); check(d == 32'hA5A5_A5A5, "R5 sel0 kept", d, 32'hA5A5A5A5);
    wr_reg(6'h0c, 32'h0);

    // R3: every pad index reaches every channel
    for (int p = 0; p < 256; p++) begin
      set_sel_all(8'(p), 8'd0);
      @(negedge clk); pads = '0; pads[p] = 1'b1;
      repeat (6) @(negedge clk);
      check(irq == 8'hFF, "R3 one-hot pad", {24'h0, irq}, 32'hFF);
      pads = ~pads;
      repeat (6) @(negedge clk);
      check(irq == 8'h00, "R3 inverted one-hot pad", {24'h0, irq}, 0);
    end

    // R11 + R3: distinct selectors against a computed pad pattern
    for (int it = 0; it < 64; it++) begin
      logic [7:0] exp;
      set_sel_all(8'(it*29 + 7), 8'd31);
      @(negedge clk);
      for (int i = 0; i < 256; i++) pads[i] = (((i*13 + it*5) % 7) < 3);
      repeat (6) @(negedge clk);
      for (int c = 0; c < 8; c++) exp[c] = pads[8'(it*29 + 7 + c*31)];
      check(irq == exp, "R11 routing pattern", {24'h0, irq}, {24'h0, exp});
    end

    // R7 R8 R9 R11: per-channel modes in rotation; channel c uses pad c*32+5
    set_sel_all(8'd5, 8'd32);
    for (int m = 0; m < 4; m++) begin
      logic [31:0] mw;
      int er[8], ef[8];
      mw = '0;
      for (int c = 0; c < 8; c++) begin
        int mc;
        mc = (m + c) % 4;
        mw[c]      = mc[0];
        mw[16 + c] = mc[1];
        er[c] = mc[0] ? (mc[1] ? 0 : 1)  : (mc[1] ? 3 : 17);
        ef[c] = mc[0] ? (mc[1] ? 1 : 0)  : (mc[1] ? 17 : 3);
      end
      @(negedge clk); pads = '0;
      wr_reg(6'h00, mw);
      repeat (10) @(negedge clk);
      for (int c = 0; c < 8; c++) pads[c*32 + 5] = 1'b1;
      window(20);
      for (int c = 0; c < 8; c++)
        check(hi_cnt[c] == er[c], "R7 R8 R9 R11 rise window",
              32'(hi_cnt[c]), 32'(er[c]));
      for (int c = 0; c < 8; c++) pads[c*32 + 5] = 1'b0;
      window(20);
      for (int c = 0; c < 8; c++)
        check(hi_cnt[c] == ef[c], "R7 R8 R9 R11 fall window",
              32'(hi_cnt[c]), 32'(ef[c]));
    end

    // R10: channel c debounce value c; pulses straddle each N*8 boundary
    @(negedge clk); pads = '0;
    wr_reg(6'h00, 32'h0);
    wr_reg(6'h0c, 32'h7654_3210);
    repeat (80) @(negedge clk);
    for (int f = 0; f < 8; f++) begin
      for (int v = 0; v < 2; v++) begin
        int len;
        bit seen[8];
        len = (f == 0) ? 1 : f*8 - 1 + v;
        if (f == 0 && v == 1) continue;
        for (int c = 0; c < 8; c++) seen[c] = 1'b0;
        @(negedge clk);
        for (int c = 0; c < 8; c++) pads[c*32 + 5] = 1'b1;
        for (int k = 1; k <= len + 150; k++) begin
          @(negedge clk);
          if (k == len) pads = '0;
          for (int c = 0; c < 8; c++) if (irq[c]) seen[c] = 1'b1;
        end
        for (int c = 0; c < 8; c++) begin
          bit exp_seen;
          exp_seen = (c == 0) ? 1'b1 : (len >= c*8);
          check(seen[c] == exp_seen, "R10 debounce boundary",
                32'(seen[c]), 32'(exp_seen));
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule